// File: doc/BRIEF.md
# Normalization Shift Amount Unit

This unit works out how far a 32-bit operand would have to be shifted left to be normalized. It has two counting modes. The unsigned mode returns the number of zero bits above the most significant one. The signed mode returns the number of redundant sign bits, meaning the bits directly below the sign bit that are copies of it. A datapath feeds it an operand, a mode bit and a valid strobe. One clock later it presents the shift amount with a matching valid strobe.

Internally, a mode-dependent front stage inverts negative operands in signed mode. A leading-zero counter built as a balanced binary priority tree follows it, then a small stage that turns the raw count into the final amount. The result is registered. It keeps its value while no new operand arrives, so a consumer can read it later.

Top module: `normshift_top`

## Requirements
- R1: With `in_mode` = 0 (unsigned), the amount is the number of consecutive zero bits starting at bit 31 and moving toward bit 0, stopping at the first one bit.
- R2: With `in_mode` = 0 and an all-zero operand, the amount is 32.
- R3: With `in_mode` = 1 (signed), the amount is the number of consecutive bits starting at bit 30 and moving toward bit 0 that equal bit 31. Internally, an operand with bit 31 set is inverted, and the result is its leading-zero count minus one.
- R4: With `in_mode` = 1, both the all-zero operand and the all-ones operand give 31.
- R5: The amount never exceeds 32, and it never exceeds 31 in signed mode.
- R6: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. `out_amount` belongs to the operand sampled on that edge, and operands may arrive on back-to-back cycles.
- R7: While `in_valid` is low, `out_amount` keeps its previous value whatever `in_operand` and `in_mode` do.
- R8: A synchronous active-high `rst` clears `out_valid` and sets `out_amount` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 1 | 0 = leading-zero count, 1 = redundant-sign-bit count |
| in_operand | input | 32 | Value to be measured |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_amount | output | 6 | Shift amount, 0 to 32 |

## Verification
The hardest situations to reach from the ports are the tree's internal boundaries, where the first significant bit sits right at the edge between two subtrees at each level. The stimulus reaches them by walking a single one bit, and in signed mode a single flipped bit below a set or clear sign, through every position. It also sends runs of ones below each position so that lower subtrees are never empty. The two signed extremes, all zeros and all ones, are sent back to back with unsigned zero. This shows that only the mode decides between 31 and 32.

// File: rtl/normshift_pkg.sv
package normshift_pkg;

  typedef enum logic {
    MODE_LZ   = 1'b0,
    MODE_SIGN = 1'b1
  } shift_mode_e;

  localparam int DEF_DATA_W = 32;

endpackage

// File: rtl/normshift_prep.sv
module normshift_prep
  import normshift_pkg::*;
#(
  parameter int W = DEF_DATA_W
) (
  input  logic        [W-1:0] operand,
  input  shift_mode_e         mode,
  output logic        [W-1:0] vec,
  output logic                vec_zero
);

  logic flip;

  // signed mode folds negative values onto positive ones
  assign flip     = (mode == MODE_SIGN) && operand[W-1];
  assign vec      = flip ? ~operand : operand;
  assign vec_zero = (vec == '0);

endmodule

// File: rtl/normshift_lzc.sv
module normshift_lzc #(
  parameter  int W  = 32,
  localparam int LV = $clog2(W),
  localparam int CW = LV + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);

  // node j of level k covers bits [j*2^k +: 2^k]; child 2j+1 is the upper half
  for (genvar k = 1; k <= LV; k++) begin : g_lvl
    localparam int N = W >> k;
    logic [N-1:0]        any;
    logic [N-1:0][k-1:0] pos;
    for (genvar j = 0; j < N; j++) begin : g_node
      if (k == 1) begin : g_leaf
        assign any[j] = vec[2*j+1] | vec[2*j];
        assign pos[j] = ~vec[2*j+1];
      end else begin : g_inner
        logic hi_any;
        logic lo_any;
        logic [k-2:0] hi_pos;
        logic [k-2:0] lo_pos;
        assign hi_any = g_lvl[k-1].any[2*j+1];
        assign lo_any = g_lvl[k-1].any[2*j];
        assign hi_pos = g_lvl[k-1].pos[2*j+1];
        assign lo_pos = g_lvl[k-1].pos[2*j];
        assign any[j] = hi_any | lo_any;
        assign pos[j] = hi_any ? {1'b0, hi_pos} : {1'b1, lo_pos};
      end
    end
  end

  logic          root_any;
  logic [LV-1:0] root_pos;

  assign root_any = g_lvl[LV].any[0];
  assign root_pos = g_lvl[LV].pos[0];
  assign count    = root_any ? {1'b0, root_pos} : CW'(W);

endmodule

// File: rtl/normshift_amount.sv
module normshift_amount
  import normshift_pkg::*;
#(
  parameter  int W  = DEF_DATA_W,
  localparam int CW = $clog2(W) + 1
) (
  input  shift_mode_e         mode,
  input  logic       [CW-1:0] count,
  output logic       [CW-1:0] amount
);

  // after folding, the sign bit is always zero in signed mode,
  // so count >= 1 there and the subtraction cannot wrap
  function automatic logic [CW-1:0] to_amount(input shift_mode_e m,
                                              input logic [CW-1:0] c);
    if (m == MODE_SIGN) return c - CW'(1);
    else                return c;
  endfunction

  assign amount = to_amount(mode, count);

endmodule

// File: rtl/normshift_top.sv
module normshift_top
  import normshift_pkg::*;
#(
  parameter  int W  = DEF_DATA_W,
  localparam int CW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_mode,
  input  logic [W-1:0]  in_operand,
  output logic          out_valid,
  output logic [CW-1:0] out_amount
);

  shift_mode_e   mode_sel;
  logic [W-1:0]  norm_vec;
  logic          vec_zero;
  logic [CW-1:0] lzc_count;
  logic [CW-1:0] next_amount;

  assign mode_sel = shift_mode_e'(in_mode);

  normshift_prep #(.W(W)) u_prep (
    .operand  (in_operand),
    .mode     (mode_sel),
    .vec      (norm_vec),
    .vec_zero (vec_zero)
  );

  normshift_lzc #(.W(W)) u_lzc (
    .vec   (norm_vec),
    .count (lzc_count)
  );

  normshift_amount #(.W(W)) u_amt (
    .mode   (mode_sel),
    .count  (lzc_count),
    .amount (next_amount)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_amount <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_amount <= next_amount;
    end
  end

endmodule

// File: rtl/normshift_chk.sv
module normshift_chk #(
  parameter  int W  = 32,
  localparam int CW = $clog2(W) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_mode,
  input logic [W-1:0]  in_operand,
  input logic [W-1:0]  norm_vec,
  input logic          vec_zero,
  input logic [CW-1:0] lzc_count,
  input logic          out_valid,
  input logic [CW-1:0] out_amount
);

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  amount_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_amount));

  // R2
  lz_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mode && in_operand == '0) |=> out_amount == CW'(W));

  // R4
  sign_extreme_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode && (in_operand == '0 || in_operand == '1))
      |=> out_amount == CW'(W - 1));

  // R5
  sign_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode) |=> out_amount <= CW'(W - 1));

  // R5
  amount_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_amount <= CW'(W));

  // R3
  fold_msb_chk: assert property (@(posedge clk) disable iff (rst)
    in_mode |-> !norm_vec[W-1]);

  // R1
  tree_zero_chk: assert property (@(posedge clk) disable iff (rst)
    vec_zero == (lzc_count == CW'(W)));

endmodule

bind normshift_top normshift_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_mode    (in_mode),
  .in_operand (in_operand),
  .norm_vec   (norm_vec),
  .vec_zero   (vec_zero),
  .lzc_count  (lzc_count),
  .out_valid  (out_valid),
  .out_amount (out_amount)
);

// File: tb/normshift_top_tb_top.sv
`timescale 1ns/1ps
module normshift_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_mode;
  logic [31:0] in_operand;
  logic        out_valid;
  logic [5:0]  out_amount;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  normshift_top dut_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_amount (out_amount)
  );

  // reference: walk from the top counting zeros
  function automatic int ref_lz(input logic [31:0] v);
    int n = 0;
    int i = 31;
    while (i >= 0 && v[i] == 1'b0) begin
      n++;
      i--;
    end
    return n;
  endfunction

  // reference: bits below the sign that copy it
  function automatic int ref_sign(input logic [31:0] v);
    int n = 0;
    int i = 30;
    while (i >= 0 && v[i] == v[31]) begin
      n++;
      i--;
    end
    return n;
  endfunction

  function automatic int ref_amt(input logic m, input logic [31:0] v);
    return m ? ref_sign(v) : ref_lz(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one operand at a falling edge, check one cycle later
  task automatic one_shot(input string req, input logic m, input logic [31:0] v,
                          input int exp);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_operand = v;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, int'(out_valid), 1);
    check(req, int'(out_amount), exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_mode = 1'b0; in_operand = 32'h0;
    @(negedge clk);
    @(negedge clk);
    check("R8", int'(out_valid), 0);
    check("R8", int'(out_amount), 0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_lz_patterns();
    one_shot("R1", 1'b0, 32'h8000_0000, 0);
    one_shot("R1", 1'b0, 32'h0000_0001, 31);
    one_shot("R1", 1'b0, 32'h0001_FFFF, 15);
    one_shot("R1", 1'b0, 32'hFFFF_FFFF, 0);
    one_shot("R2", 1'b0, 32'h0000_0000, 32);
    for (int p = 0; p < 32; p++) begin
      one_shot("R1", 1'b0, 32'h1 << p, 31 - p);
      one_shot("R1", 1'b0, (32'h1 << p) | ((32'h1 << p) - 32'h1), 31 - p);
    end
  endtask

  task automatic t_sign_patterns();
    one_shot("R3", 1'b1, 32'h4000_0000, 0);
    one_shot("R3", 1'b1, 32'h8000_0000, 0);
    one_shot("R3", 1'b1, 32'hFFFF_FFFE, 30);
    one_shot("R3", 1'b1, 32'h0000_0001, 30);
    one_shot("R3", 1'b1, 32'hFFF0_1234, 11);
    for (int p = 0; p < 31; p++) begin
      one_shot("R3", 1'b1, 32'h1 << p, 30 - p);
      one_shot("R3", 1'b1, ~(32'h1 << p), 30 - p);
    end
  endtask

  task automatic t_extremes();
    one_shot("R4", 1'b1, 32'h0000_0000, 31);
    one_shot("R4", 1'b1, 32'hFFFF_FFFF, 31);
    one_shot("R2", 1'b0, 32'h0000_0000, 32);
    one_shot("R5", 1'b0, 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_hold();
    one_shot("R7", 1'b0, 32'h0000_0100, 23);
    for (int i = 0; i < 4; i++) begin
      in_mode = i[0]; in_operand = 32'h0 + i;
      @(negedge clk);
      check("R6", int'(out_valid), 0);
      check("R7", int'(out_amount), 23);
    end
  endtask

  task automatic t_stream();
    logic [31:0] lf = 32'hACE1_2468;
    int exp = 0;
    bit have = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (have) begin
        check("R6", int'(out_valid), 1);
        check(in_mode ? "R3" : "R1", int'(out_amount), exp);
        check("R5", int'(out_amount <= (in_mode ? 6'd31 : 6'd32)), 1);
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      in_valid = 1'b1;
      in_mode = lf[3];
      in_operand = lf >> (lf[9:5]);
      if (lf[4]) in_operand = ~in_operand;
      exp = ref_amt(in_mode, in_operand);
      have = 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", int'(out_valid), 1);
    check(in_mode ? "R3" : "R1", int'(out_amount), exp);
    @(negedge clk);
    check("R6", int'(out_valid), 0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_operand = '0;
    t_reset();
    t_lz_patterns();
    t_sign_patterns();
    t_extremes();
    t_hold();
    t_stream();
    t_reset();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule